// File: doc/BRIEF.md
# Open-Drain Pad Control Register for Bit-Banged I2C

This block is a single 32-bit control register that lets software toggle the clock and data lines of an I2C bus directly. Each line has its own byte-wide lane in the register. The lane holds four things: a direction bit, a level bit, a bit that disables the pad's pull-up, and a read-only copy of the live pad level. Pads are driven open-drain. When a pad's direction bit selects output, the output enable asserts and the pad output drives 0. When the direction bit selects input, the line is released and the external pull-up takes it high.

The direction bit and the level bit each have a companion strobe bit in the same lane. A write changes the direction or the level only when that strobe is set in the same word. Software can therefore release or pull down one line with a single store, with no read-modify-write. The pull-up-disable bit has no strobe. Every write loads it, so software writes the value it read back to keep it. The pad levels pass through a two-flop synchronizer before they appear in the read data.

Top module: `od_pin_ctrl_reg`

## Requirements
- R1: After reset the direction, level and pull-up-disable bits are all 0 and both output enables are low. With both pads high, the read word is 0x0000_1010.
- R2: The direction bit of a lane takes the written value only when its strobe is 1 in the same write. Otherwise it holds. Strobe positions are bit 0 for the clock lane and bit 8 for the data lane. Direction positions are bits 1 and 9, where 1 means output.
- R3: The level bit of a lane takes the written value only when its strobe is 1 in the same write. Otherwise it holds. Strobe positions are bits 2 and 10. Level positions are bits 3 and 11.
- R4: A pad's output enable equals its direction bit. Writing direction 0 with its strobe releases the line, which drops the output enable.
- R5: Writing direction 1 and level 0 with both strobes set raises the output enable, and the pad output value is 0.
- R6: The pull-up-disable bits sit at bits 5 and 13. Every write loads them whatever the strobes are, so writing back the value read keeps them unchanged.
- R7: Bits 4 and 12 read the clock and data pad levels, whatever the direction. A pad change shows in the read word two clock edges after it is sampled, not one.
- R8: Strobe bits read as 0. Written values in the input-level positions and in bits 6, 7 and 14 to 31 have no effect, and those positions read as 0.
- R9: A write changes only its own lane's direction and level. A write with no strobes set in the other lane leaves that lane's direction and level unchanged.
- R10: Register updates take effect on the clock edge that samples the write. The read word is a combinational view of the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Current register contents and synchronized pad levels |
| pad_in | input | 2 | Raw pad levels (bit 0 clock, bit 1 data) |
| pad_oe | output | 2 | Pad output enables (bit 0 clock, bit 1 data) |
| pad_out | output | 2 | Pad output values, 0 whenever enabled |

## Verification
The bench writes direction and level values with the strobe cleared. A design that loads without the strobe would let a stray write release or grab a line. The bench checks that a write aimed at one lane leaves the other lane alone, and that the pull-up-disable bit follows every write, both with and without strobes. It moves the pad inputs while a lane is an output and samples after one edge and after two. A design with the wrong synchronizer depth, or one that masks the input by direction, would show the wrong level at one of those points. It also writes all ones, to catch strobes or input positions leaking into the read word.

// File: rtl/odpin_pkg.sv
package odpin_pkg;

    localparam int REG_W      = 32;
    localparam int LANE_W     = 8;
    localparam int PAD_COUNT  = 2;

    localparam int OFS_DIR_STB = 0;
    localparam int OFS_DIR     = 1;
    localparam int OFS_LVL_STB = 2;
    localparam int OFS_LVL     = 3;
    localparam int OFS_IN      = 4;
    localparam int OFS_PUD     = 5;

    typedef struct packed {
        logic dir_stb;
        logic dir;
        logic lvl_stb;
        logic lvl;
        logic pud;
    } lane_wr_t;

    typedef struct packed {
        logic dir;
        logic lvl;
        logic pud;
    } lane_state_t;

    function automatic lane_wr_t lane_decode(input logic [LANE_W-1:0] b);
        lane_wr_t r;
        r.dir_stb = b[OFS_DIR_STB];
        r.dir     = b[OFS_DIR];
        r.lvl_stb = b[OFS_LVL_STB];
        r.lvl     = b[OFS_LVL];
        r.pud     = b[OFS_PUD];
        return r;
    endfunction

    function automatic logic [LANE_W-1:0] lane_encode(input lane_state_t s, input logic lvl_in);
        logic [LANE_W-1:0] b;
        b             = '0;
        b[OFS_DIR]    = s.dir;
        b[OFS_LVL]    = s.lvl;
        b[OFS_IN]     = lvl_in;
        b[OFS_PUD]    = s.pud;
        return b;
    endfunction

endpackage

// File: rtl/odpin_sync.sv
module odpin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/odpin_lane.sv
module odpin_lane
    import odpin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  lane_wr_t    wr,
    output lane_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_en) begin
            if (wr.dir_stb) st.dir <= wr.dir;
            if (wr.lvl_stb) st.lvl <= wr.lvl;
            st.pud <= wr.pud;
        end
    end
endmodule

// File: rtl/od_pin_ctrl_reg.sv
module od_pin_ctrl_reg
    import odpin_pkg::*;
#(
    parameter int NUM_PADS    = PAD_COUNT,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_out
);
    localparam int USED_W = NUM_PADS * LANE_W;

    logic [NUM_PADS-1:0] lvl_sync;
    logic [LANE_W-1:0]   lane_rd [NUM_PADS];

    odpin_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl_sync)
    );

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_lane
        lane_wr_t    wr;
        lane_state_t st;

        assign wr = lane_decode(wdata[i*LANE_W +: LANE_W]);

        odpin_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .wr    (wr),
            .st    (st)
        );

        assign pad_oe[i]  = st.dir;
        assign pad_out[i] = 1'b0;
        assign lane_rd[i] = lane_encode(st, lvl_sync[i]);
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PADS; i++) rdata[i*LANE_W +: LANE_W] = lane_rd[i];
    end

    initial begin
        if (USED_W > REG_W) $error("pad lanes exceed register width");
    end
endmodule

// File: rtl/odpin_chk.sv
module odpin_chk
    import odpin_pkg::*;
#(
    parameter int NUM_PADS    = PAD_COUNT,
    parameter int SYNC_STAGES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [REG_W-1:0]    wdata,
    input logic [REG_W-1:0]    rdata,
    input logic [NUM_PADS-1:0] pad_in,
    input logic [NUM_PADS-1:0] pad_oe
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
        localparam int B = i * LANE_W;

        AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wdata[B+OFS_DIR_STB]) |=> $stable(pad_oe[i])); // R2
        AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wdata[B+OFS_DIR_STB]) |=> pad_oe[i] == $past(wdata[B+OFS_DIR])); // R4
        AST_LVL_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wdata[B+OFS_LVL_STB]) |=> $stable(rdata[B+OFS_LVL])); // R3
        AST_PUD_LOAD: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> rdata[B+OFS_PUD] == $past(wdata[B+OFS_PUD])); // R6

        if (SYNC_STAGES == 2) begin : g_sync2
            AST_IN_LATENCY: assert property (@(posedge clk) disable iff (rst)
                (age >= 2'd2) |-> rdata[B+OFS_IN] == $past(pad_in[i], 2)); // R7
        end
    end
endmodule

bind od_pin_ctrl_reg odpin_chk #(.NUM_PADS(NUM_PADS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .pad_in (pad_in),
    .pad_oe (pad_oe)
);

// File: tb/sim_od_pin_ctrl_reg.sv
module sim_od_pin_ctrl_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pad_in = 2'b11;
    logic [1:0]  pad_oe;
    logic [1:0]  pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] m_dir = '0;
    logic [1:0] m_lvl = '0;
    logic [1:0] m_pud = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    od_pin_ctrl_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [7:0] lane(input bit ds, input bit d, input bit ls, input bit l, input bit p);
        return {2'b00, p, 1'b0, l, ls, d, ds};
    endfunction

    function automatic logic [31:0] exp_word(input logic [1:0] lvl_in);
        logic [31:0] w = '0;
        for (int i = 0; i < 2; i++) begin
            w[i*8+1] = m_dir[i];
            w[i*8+3] = m_lvl[i];
            w[i*8+4] = lvl_in[i];
            w[i*8+5] = m_pud[i];
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = w;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
        for (int i = 0; i < 2; i++) begin
            if (w[i*8+0]) m_dir[i] = w[i*8+1];
            if (w[i*8+2]) m_lvl[i] = w[i*8+3];
            m_pud[i] = w[i*8+5];
        end
    endtask

    task automatic t_reset;
        check("R1 rdata", rdata, 32'h0000_1010);
        check("R1 oe", {30'd0, pad_oe}, 32'd0);
        check("R1 out", {30'd0, pad_out}, 32'd0);
    endtask

    task automatic t_dir_strobe;
        write({16'd0, 8'd0, lane(1, 1, 0, 0, 0)});
        check("R2 dir loads with strobe", rdata, exp_word(2'b11));
        check("R4 oe follows dir", {30'd0, pad_oe}, 32'd1);
        write({16'd0, 8'd0, lane(0, 0, 0, 0, 0)});
        check("R2 dir held without strobe", {30'd0, pad_oe}, 32'd1);
        write({16'd0, 8'd0, lane(1, 0, 0, 0, 0)});
        check("R4 release drops oe", {30'd0, pad_oe}, 32'd0);
        check("R10 rdata after release", rdata, exp_word(2'b11));
    endtask

    task automatic t_lvl_strobe;
        write({16'd0, lane(0, 0, 0, 1, 0), 8'd0});
        check("R3 level held without strobe", rdata, exp_word(2'b11));
        write({16'd0, lane(0, 0, 1, 1, 0), 8'd0});
        check("R3 level loads with strobe", rdata[11], 1'b1);
        write({16'd0, lane(0, 0, 0, 0, 0), 8'd0});
        check("R3 level held again", rdata, exp_word(2'b11));
    endtask

    task automatic t_drive_low;
        write({16'd0, 8'd0, lane(1, 1, 0, 0, 0)});
        write({16'd0, lane(1, 1, 1, 0, 0), 8'd0});
        check("R5 oe high", {30'd0, pad_oe}, 32'd3);
        check("R5 out low", {30'd0, pad_out}, 32'd0);
        check("R9 clock lane kept", rdata, exp_word(2'b11));
        write({16'd0, 8'd0, lane(1, 0, 0, 0, 0)});
        check("R9 data lane kept", {30'd0, pad_oe}, 32'd2);
    endtask

    task automatic t_pud;
        write({16'd0, 8'd0, lane(0, 0, 0, 0, 1)});
        check("R6 pud loads without strobe", rdata, exp_word(2'b11));
        write({16'd0, 8'd0, lane(1, 1, 0, 0, 1)});
        check("R6 pud written back", rdata[5], 1'b1);
        write({16'd0, lane(0, 0, 0, 0, 1), lane(0, 0, 0, 0, 0)});
        check("R6 pud cleared, data pud set", rdata, exp_word(2'b11));
    endtask

    task automatic t_all_ones;
        write(32'hFFFF_FFFF);
        check("R8 strobes and spare bits read 0", rdata, exp_word(2'b11));
        check("R8 exact word", rdata, 32'h0000_3A3A);
    endtask

    task automatic t_input;
        @(negedge clk);
        pad_in = 2'b01;
        @(negedge clk);
        check("R7 one edge not yet visible", rdata[12], 1'b1);
        @(negedge clk);
        check("R7 data low after two edges while output", rdata, exp_word(2'b01));
        pad_in = 2'b10;
        @(negedge clk);
        @(negedge clk);
        check("R7 clock low, data high", rdata, exp_word(2'b10));
        write({16'd0, lane(1, 0, 0, 0, 0), lane(1, 0, 0, 0, 0)});
        check("R7 level independent of direction", rdata, exp_word(2'b10));
        pad_in = 2'b11;
        @(negedge clk);
        @(negedge clk);
        check("R7 both high", rdata, exp_word(2'b11));
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_strobe();
        t_lvl_strobe();
        t_drive_low();
        t_pud();
        t_all_ones();
        t_input();
        done = 1'b1;
        summary();
    end
endmodule